// File: doc/BRIEF.md
# Dual-Bank Coprocessor Memory Bridge

This block lets a host processor and a coprocessor share two 32 KB RAM banks. A single ownership bit gives one bank to each side and swaps them on demand. Each side reaches its bank through a 16 KB window that shows one half of the bank, and a half-select bit picks which half. The host window is split into two 8 KB sub-windows that can each be switched between the bank and the host's own system memory. The coprocessor window can sit at the top or the middle of its address space. Addresses that fall outside the windows go to local memory.

Each bus has a small control register. Bit 7 of both registers is the same storage bit and works as a mailbox semaphore. A host-owned soft-reset bit holds the coprocessor in reset and pins the coprocessor's private control bits to their defaults. A typical boot goes like this. The host holds the coprocessor in reset and maps the bank in. It writes a reset vector at the top of the upper half. It swaps ownership so the coprocessor gets that bank. It clears the semaphore and releases reset. It then waits for the coprocessor to set the semaphore again.

Chip selects and bank addresses are decoded combinationally from the live address and the register state. Read data comes back in the same cycle. Register writes take effect at the clock edge. Parameters `H_SEM_INV` and `C_SEM_INV` can invert the semaphore polarity seen by either side. By default neither side is inverted.

Top module: `dual_bank_bridge`

## Requirements
- R1: When ownership bit (host bit 1) is 0 the host reaches bank 0 and the coprocessor bank 1; when it is 1 the host reaches bank 1 and the coprocessor bank 0. `bank_cs[i]` selects bank i. The two sides never select the same bank.
- R2: Host addresses 0x8000–0x9FFF select the bank only while host bit 4 is 1. Host addresses 0xA000–0xBFFF select the bank only while host bit 5 is 1. Any other host access that is not the register raises `h_local_cs`. Both bits reset to 0.
- R3: The bank offset is {half, address[13:0]}. The host half bit is host bit 3 and the coprocessor half bit is coprocessor bit 5. Both reset to 1, and 0 selects the lower half. So host 0xBFFC and coprocessor 0xFFFC, both in the upper half, reach the same byte.
- R4: When coprocessor bit 6 is 0 (its reset value), the coprocessor bank window is 0xC000–0xFFFF. When it is 1, the window is 0x4000–0x7FFF. Every other non-register coprocessor access raises `c_local_cs`.
- R5: The host register is at 0xD5C0 and reads {sem, 1, b5, b4, hhalf, 1, own, srst}; it reads 0xCC after reset. The coprocessor register answers anywhere in 0x0200–0x020F and reads {sem, win, chalf, 1,1,1,1,1}; it reads 0xBF after reset. Bank reads return the selected bank's data.
- R6: Host bit 0 is soft reset and resets to 0. While it is 0, `cop_reset` is 1, coprocessor bits 6 and 5 are forced to 0 and 1, and coprocessor register writes are ignored, including the semaphore.
- R7: Bit 7 of both registers is one shared semaphore with reset value 1. A write from either side sets it to the written bit 7. Without a write it holds its value.
- R8: If both sides write the semaphore in the same cycle, the host value wins. A register read made during a write cycle returns the value from before the write.
- R9: A change to the ownership, window or half bits steers the very next bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_addr | input | 16 | Host address |
| h_wdata | input | 8 | Host write data |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_rdata | output | 8 | Host read data (register or bank; 0xFF otherwise) |
| h_local_cs | output | 1 | Host access goes to host system memory |
| c_addr | input | 16 | Coprocessor address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rd | input | 1 | Coprocessor read strobe |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rdata | output | 8 | Coprocessor read data (register or bank; 0xFF otherwise) |
| c_local_cs | output | 1 | Coprocessor access goes to its local RAM |
| cop_reset | output | 1 | Coprocessor reset, active high |
| bank_cs | output | 2 | Chip select per shared bank |
| bank_we | output | 2 | Write enable per shared bank |
| bank_addr | output | 2x15 | Byte offset per shared bank |
| bank_wdata | output | 2x8 | Write data per shared bank |
| bank_rdata | input | 2x8 | Read data per shared bank |

## Verification
The bench runs the full boot handshake. It plants a vector through the host's upper half, swaps ownership and reads the vector back from the coprocessor's top addresses. A bridge that adds no half offset, or that does not cross the banks, returns a zero vector or drives the wrong `bank_cs` bit. Same-cycle semaphore writes from both sides catch a design that lets the coprocessor win. A coprocessor register read made during a host write catches a design that forwards the new value. Coprocessor writes made during soft reset catch a design that lets them change the window bit or the semaphore. Reads of both 8 KB host sub-windows and of both coprocessor window positions catch a swapped enable bit or an inverted window decode.

// File: rtl/dbb_pkg.sv
package dbb_pkg;
   localparam int DATA_W  = 8;
   localparam int ADDR_W  = 16;
   localparam int WIN_AW  = 14;
   localparam int BANK_AW = WIN_AW + 1;
   localparam int N_BANKS = 2;

   typedef struct packed {
      logic                cs;
      logic                we;
      logic [BANK_AW-1:0]  off;
      logic [DATA_W-1:0]   wdata;
   } bank_req_t;

   typedef struct packed {
      logic sem;
      logic hub;     // host upper sub-window enable
      logic hlb;     // host lower sub-window enable
      logic hhalf;
      logic own;
      logic srst;
      logic win;
      logic chalf;
   } ctl_t;
endpackage

// File: rtl/dbb_ctrl_regs.sv
module dbb_ctrl_regs
   import dbb_pkg::*;
#(
   parameter bit H_SEM_INV = 1'b0,
   parameter bit C_SEM_INV = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_reg_wr,
   input  logic [5:0]        h_wbits,   // {b7,b5,b4,b3,b1,b0}
   input  logic              c_reg_wr,
   input  logic [2:0]        c_wbits,   // {b7,b6,b5}
   output ctl_t              ctl,
   output logic [DATA_W-1:0] h_reg_rd,
   output logic [DATA_W-1:0] c_reg_rd,
   output logic              cop_reset
);
   logic c_we_ok, h_sem_new, c_sem_new, h_sem_view, c_sem_view;

   assign c_we_ok = c_reg_wr & ctl.srst;

   generate
      if (H_SEM_INV) begin : g_h_inv
         assign h_sem_new  = ~h_wbits[5];
         assign h_sem_view = ~ctl.sem;
      end else begin : g_h_pass
         assign h_sem_new  = h_wbits[5];
         assign h_sem_view = ctl.sem;
      end
      if (C_SEM_INV) begin : g_c_inv
         assign c_sem_new  = ~c_wbits[2];
         assign c_sem_view = ~ctl.sem;
      end else begin : g_c_pass
         assign c_sem_new  = c_wbits[2];
         assign c_sem_view = ctl.sem;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '{sem:1'b1, hub:1'b0, hlb:1'b0, hhalf:1'b1, own:1'b0,
                  srst:1'b0, win:1'b0, chalf:1'b1};
      end else begin
         if (h_reg_wr) begin
            ctl.hub   <= h_wbits[4];
            ctl.hlb   <= h_wbits[3];
            ctl.hhalf <= h_wbits[2];
            ctl.own   <= h_wbits[1];
            ctl.srst  <= h_wbits[0];
         end
         if (h_reg_wr)     ctl.sem <= h_sem_new;
         else if (c_we_ok) ctl.sem <= c_sem_new;
         if (!ctl.srst) begin
            ctl.win   <= 1'b0;
            ctl.chalf <= 1'b1;
         end else if (c_we_ok) begin
            ctl.win   <= c_wbits[1];
            ctl.chalf <= c_wbits[0];
         end
      end
   end

   assign h_reg_rd  = {h_sem_view, 1'b1, ctl.hub, ctl.hlb, ctl.hhalf, 1'b1, ctl.own, ctl.srst};
   assign c_reg_rd  = {c_sem_view, ctl.win, ctl.chalf, 5'b11111};
   assign cop_reset = ~ctl.srst;

   p_cop_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.srst |=> (!ctl.win && ctl.chalf));
   p_sem_host_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (h_reg_wr && c_reg_wr && ctl.srst) |=> (ctl.sem == $past(h_sem_new)));
   p_sem_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!h_reg_wr && !c_reg_wr) |=> $stable(ctl.sem));
endmodule

// File: rtl/dbb_host_map.sv
module dbb_host_map
   import dbb_pkg::*;
#(
   parameter logic [15:0] REG_ADDR = 16'hD5C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   input  logic              wr,
   input  logic              lo_en,
   input  logic              hi_en,
   input  logic              half,
   output bank_req_t         req,
   output logic              reg_sel,
   output logic              local_cs
);
   logic win_hit, bank_hit;

   assign win_hit  = (addr[ADDR_W-1:WIN_AW] == 2'b10);
   assign bank_hit = win_hit & (addr[WIN_AW-1] ? hi_en : lo_en);
   assign reg_sel  = (addr == REG_ADDR);
   assign local_cs = (rd | wr) & ~bank_hit & ~reg_sel;

   assign req.cs    = bank_hit & (rd | wr);
   assign req.we    = bank_hit & wr;
   assign req.off   = {half, addr[WIN_AW-1:0]};
   assign req.wdata = wdata;

   p_host_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req.cs |-> (addr >= 16'h8000 && addr <= 16'hBFFF));
endmodule

// File: rtl/dbb_cop_map.sv
module dbb_cop_map
   import dbb_pkg::*;
#(
   parameter logic [15:0] REG_BASE = 16'h0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd,
   input  logic              wr,
   input  logic              win,
   input  logic              half,
   output bank_req_t         req,
   output logic              reg_sel,
   output logic              local_cs
);
   logic [1:0] base;
   logic       bank_hit;

   if (REG_BASE[3:0] != 4'h0) begin : g_bad_base
      $error("REG_BASE must be 16-byte aligned");
   end

   assign base     = win ? 2'b01 : 2'b11;
   assign bank_hit = (addr[ADDR_W-1:WIN_AW] == base);
   assign reg_sel  = (addr[ADDR_W-1:4] == REG_BASE[15:4]);
   assign local_cs = (rd | wr) & ~bank_hit & ~reg_sel;

   assign req.cs    = bank_hit & (rd | wr);
   assign req.we    = bank_hit & wr;
   assign req.off   = {half, addr[WIN_AW-1:0]};
   assign req.wdata = wdata;

   p_cop_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req.cs |-> (addr[15] == !win && addr[14]));
endmodule

// File: rtl/dual_bank_bridge.sv
module dual_bank_bridge
   import dbb_pkg::*;
#(
   parameter bit          H_SEM_INV  = 1'b0,
   parameter bit          C_SEM_INV  = 1'b0,
   parameter logic [15:0] H_REG_ADDR = 16'hD5C0,
   parameter logic [15:0] C_REG_BASE = 16'h0200
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 h_addr,
   input  logic [DATA_W-1:0]                 h_wdata,
   input  logic                              h_rd,
   input  logic                              h_wr,
   output logic [DATA_W-1:0]                 h_rdata,
   output logic                              h_local_cs,
   input  logic [ADDR_W-1:0]                 c_addr,
   input  logic [DATA_W-1:0]                 c_wdata,
   input  logic                              c_rd,
   input  logic                              c_wr,
   output logic [DATA_W-1:0]                 c_rdata,
   output logic                              c_local_cs,
   output logic                              cop_reset,
   output logic [N_BANKS-1:0]                bank_cs,
   output logic [N_BANKS-1:0]                bank_we,
   output logic [N_BANKS-1:0][BANK_AW-1:0]   bank_addr,
   output logic [N_BANKS-1:0][DATA_W-1:0]    bank_wdata,
   input  logic [N_BANKS-1:0][DATA_W-1:0]    bank_rdata
);
   if (DATA_W != 8 || ADDR_W != 16 || N_BANKS != 2) begin : g_bad_geom
      $error("bridge geometry is fixed by the register bit layout");
   end

   ctl_t              ctl;
   bank_req_t         hreq, creq;
   logic              h_reg_sel, c_reg_sel;
   logic [DATA_W-1:0] h_reg_rd, c_reg_rd;

   dbb_ctrl_regs #(.H_SEM_INV(H_SEM_INV), .C_SEM_INV(C_SEM_INV)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .h_reg_wr(h_wr & h_reg_sel),
      .h_wbits({h_wdata[7], h_wdata[5:3], h_wdata[1:0]}),
      .c_reg_wr(c_wr & c_reg_sel),
      .c_wbits(c_wdata[7:5]),
      .ctl(ctl), .h_reg_rd(h_reg_rd), .c_reg_rd(c_reg_rd), .cop_reset(cop_reset));

   dbb_host_map #(.REG_ADDR(H_REG_ADDR)) u_hmap (
      .clk(clk), .rst_n(rst_n), .addr(h_addr), .wdata(h_wdata), .rd(h_rd), .wr(h_wr),
      .lo_en(ctl.hlb), .hi_en(ctl.hub), .half(ctl.hhalf),
      .req(hreq), .reg_sel(h_reg_sel), .local_cs(h_local_cs));

   dbb_cop_map #(.REG_BASE(C_REG_BASE)) u_cmap (
      .clk(clk), .rst_n(rst_n), .addr(c_addr), .wdata(c_wdata), .rd(c_rd), .wr(c_wr),
      .win(ctl.win), .half(ctl.chalf),
      .req(creq), .reg_sel(c_reg_sel), .local_cs(c_local_cs));

   for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      logic host_owns;
      assign host_owns     = (ctl.own == b[0]);
      assign bank_cs[b]    = host_owns ? hreq.cs    : creq.cs;
      assign bank_we[b]    = host_owns ? hreq.we    : creq.we;
      assign bank_addr[b]  = host_owns ? hreq.off   : creq.off;
      assign bank_wdata[b] = host_owns ? hreq.wdata : creq.wdata;
   end

   always_comb begin
      if (h_reg_sel)    h_rdata = h_reg_rd;
      else if (hreq.cs) h_rdata = bank_rdata[ctl.own];
      else              h_rdata = '1;
      if (c_reg_sel)    c_rdata = c_reg_rd;
      else if (creq.cs) c_rdata = bank_rdata[~ctl.own];
      else              c_rdata = '1;
   end

   p_cross_own_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hreq.cs && creq.cs) |-> (bank_cs == 2'b11));
endmodule

// File: tb/dual_bank_bridge_bench.sv
module dual_bank_bridge_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [15:0] h_addr = '0, c_addr = '0;
   logic [7:0]  h_wdata = '0, c_wdata = '0, h_rdata, c_rdata;
   logic        h_rd = 0, h_wr = 0, c_rd = 0, c_wr = 0;
   logic        h_local_cs, c_local_cs, cop_reset;
   logic [1:0]  bank_cs, bank_we;
   logic [1:0][14:0] bank_addr;
   logic [1:0][7:0]  bank_wdata, bank_rdata;

   int total = 0, bad = 0;

   dual_bank_bridge u_dual_bank_bridge (
      .clk(clk), .rst_n(rst_n),
      .h_addr(h_addr), .h_wdata(h_wdata), .h_rd(h_rd), .h_wr(h_wr),
      .h_rdata(h_rdata), .h_local_cs(h_local_cs),
      .c_addr(c_addr), .c_wdata(c_wdata), .c_rd(c_rd), .c_wr(c_wr),
      .c_rdata(c_rdata), .c_local_cs(c_local_cs), .cop_reset(cop_reset),
      .bank_cs(bank_cs), .bank_we(bank_we), .bank_addr(bank_addr),
      .bank_wdata(bank_wdata), .bank_rdata(bank_rdata));

   // simple bank models, 1K bytes each, indexed by {half, offset[8:0]}
   logic [7:0] mem [0:1][0:1023];
   function automatic logic [9:0] idx(input logic [14:0] a);
      return {a[14], a[8:0]};
   endfunction
   initial begin
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 1024; i++) mem[b][i] = 8'h00;
   end
   always @(posedge clk) begin
      for (int b = 0; b < 2; b++)
         if (bank_cs[b] && bank_we[b]) mem[b][idx(bank_addr[b])] <= bank_wdata[b];
   end
   assign bank_rdata[0] = mem[0][idx(bank_addr[0])];
   assign bank_rdata[1] = mem[1][idx(bank_addr[1])];

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic h_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1;
      @(negedge clk); h_wr = 0;
   endtask
   task automatic c_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); c_addr = a; c_wdata = d; c_wr = 1;
      @(negedge clk); c_wr = 0;
   endtask
   task automatic h_read(input logic [15:0] a, output logic [7:0] d,
                         output logic [1:0] cs, output logic lcs);
      @(negedge clk); h_addr = a; h_rd = 1; #2;
      d = h_rdata; cs = bank_cs; lcs = h_local_cs; h_rd = 0;
   endtask
   task automatic c_read(input logic [15:0] a, output logic [7:0] d,
                         output logic [1:0] cs, output logic lcs);
      @(negedge clk); c_addr = a; c_rd = 1; #2;
      d = c_rdata; cs = bank_cs; lcs = c_local_cs; c_rd = 0;
   endtask

   logic [7:0] d; logic [1:0] cs; logic lcs;

   task automatic t_reset();
      h_read(16'hD5C0, d, cs, lcs); chk("R5 host reg reset", d, 8'hCC);
      c_read(16'h0207, d, cs, lcs); chk("R5 cop reg reset", d, 8'hBF);
      chk("R6 cop_reset after reset", cop_reset, 1'b1);
      h_read(16'h8000, d, cs, lcs);
      chk("R2 lower sub-window off at reset", {cs, lcs}, 3'b001);
      c_read(16'hC010, d, cs, lcs);
      chk("R4 default window top", {cs, lcs}, 3'b100);
      c_read(16'h4010, d, cs, lcs);
      chk("R4 middle is local by default", {cs, lcs}, 3'b001);
   endtask

   task automatic t_host_window();
      h_write(16'hD5C0, 8'h90);
      h_read(16'h8000, d, cs, lcs); chk("R2 lower on", {cs, lcs}, 3'b010);
      h_read(16'hA000, d, cs, lcs); chk("R2 upper still off", {cs, lcs}, 3'b001);
      h_write(16'hD5C0, 8'hA0);
      h_read(16'hA000, d, cs, lcs); chk("R2 upper on", {cs, lcs}, 3'b010);
      h_read(16'h9FFF, d, cs, lcs); chk("R2 lower now off", {cs, lcs}, 3'b001);
   endtask

   task automatic t_boot();
      h_write(16'hD5C0, 8'hA8);            // sem1, upper sub on, half1, own0
      h_write(16'hBFFC, 8'h34);
      h_write(16'hBFFD, 8'h12);
      h_write(16'hD5C0, 8'hAA);            // swap ownership
      h_read(16'hBFFC, d, cs, lcs);
      chk("R1 R9 host now on bank 1", cs, 2'b10);
      chk("R1 bank 1 has no vector", d, 8'h00);
      h_write(16'hD5C0, 8'h0A);            // sem0, window off, own1
      h_read(16'hD5C0, d, cs, lcs); chk("R7 host sees sem cleared", d, 8'h4E);
      c_read(16'h020F, d, cs, lcs); chk("R7 cop sees sem cleared", d, 8'h3F);
      h_write(16'hD5C0, 8'h0B);            // release
      chk("R6 cop_reset released", cop_reset, 1'b0);
      c_read(16'hFFFC, d, cs, lcs);
      chk("R1 cop on bank 0", cs, 2'b01);
      chk("R3 vector low byte", d, 8'h34);
      chk("R3 bank offset", bank_addr[0], 15'h7FFC);
      c_read(16'hFFFD, d, cs, lcs); chk("R3 vector high byte", d, 8'h12);
      c_write(16'h0200, 8'hA0);            // done
      h_read(16'hD5C0, d, cs, lcs); chk("R7 host sees sem set", d, 8'hCF);
   endtask

   task automatic t_cop_window();
      c_write(16'h0205, 8'hC0);            // win1, half0, sem1
      c_read(16'h0200, d, cs, lcs); chk("R5 cop reg layout", d, 8'hDF);
      c_write(16'h4010, 8'h5A);
      c_read(16'h4010, d, cs, lcs); chk("R4 R9 middle window", {cs, lcs}, 3'b010);
      c_read(16'hC010, d, cs, lcs); chk("R4 top now local", {cs, lcs}, 3'b001);
      h_write(16'hD5C0, 8'h91);            // own0, lower sub on, half0
      h_read(16'h8010, d, cs, lcs); chk("R3 lower half shared byte", d, 8'h5A);
   endtask

   task automatic t_collide();
      @(negedge clk);
      h_addr = 16'hD5C0; h_wdata = 8'h11; h_wr = 1;
      c_addr = 16'h0200; c_wdata = 8'hC0; c_wr = 1;
      @(negedge clk); h_wr = 0; c_wr = 0;
      h_read(16'hD5C0, d, cs, lcs); chk("R8 host wins semaphore", d, 8'h55);
      @(negedge clk);
      h_addr = 16'hD5C0; h_wdata = 8'h91; h_wr = 1;
      c_addr = 16'h0203; c_rd = 1; #2;
      chk("R8 read shows pre-write value", c_rdata, 8'h5F);
      @(negedge clk); h_wr = 0; c_rd = 0;
      c_read(16'h0203, d, cs, lcs); chk("R8 new value after edge", d, 8'hDF);
   endtask

   task automatic t_soft_reset();
      h_write(16'hD5C0, 8'h90);
      c_read(16'h0200, d, cs, lcs); chk("R6 cop bits forced default", d, 8'hBF);
      chk("R6 cop_reset asserted", cop_reset, 1'b1);
      c_write(16'h0200, 8'h40);
      c_read(16'h0200, d, cs, lcs); chk("R6 cop write ignored", d, 8'hBF);
      h_read(16'hD5C0, d, cs, lcs); chk("R6 sem untouched by cop", d, 8'hD4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_host_window();
      t_boot();
      t_cop_window();
      t_collide();
      t_soft_reset();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule